// File: doc/BRIEF.md
# SPI Response Tag Scanner

This block sits on the host side of a byte-serial SPI link, after the deserialiser. It watches received bytes and finds protocol tags in a stream that may carry a variable number of filler bytes. A `start` pulse arms it for one transaction. The `mode` input chooses one of two behaviours.

In read mode the scanner skips bytes until one carries the data-start marker in its upper nibble. It then forwards the payload bytes that follow, one strobe per byte. The payload is four data bytes, plus two check bytes when `crc_en` is set. In acknowledge mode it collects a fixed window of received bytes and picks the most recent response-start byte inside it. Picking the most recent one discards stale acknowledgements of earlier packets that a short final packet can leave behind. It then checks that byte's packet type and the status byte after it.

At the end the scanner reports a held `found` or a held `error`, never both.

Top module: `spi_tag_scanner`

## Requirements
- R1: After reset, and in the cycle after any `start` pulse, `found`, `error` and `pay_valid` are 0. `busy` is 0 after reset and 1 after `start`.
- R2: In read mode (`mode`=0), every accepted byte whose bits 7:4 are not 0xF is skipped as filler. The first byte with bits 7:4 equal to 0xF is taken as the data-start tag, provided it is among the first 8 accepted bytes.
- R3: In read mode, if 8 accepted bytes pass without a data-start tag, `error` rises in the cycle after the 8th byte and no payload is forwarded.
- R4: After the tag, the next 4 accepted bytes are forwarded, or 6 when `crc_en` was 1 at `start`. Each one appears on `pay_data` with `pay_valid` high for one cycle, in the cycle after the byte is accepted. `found` rises together with the strobe of the last payload byte.
- R5: `pay_valid` is never raised for a filler byte, for the tag byte, or at any time in acknowledge mode.
- R6: In acknowledge mode (`mode`=1), exactly 4 accepted bytes form the window, positions 0 to 3 in arrival order. The chosen byte is the latest one among positions 0 to 2 whose bits 7:4 equal 0xC. Position 3 is never chosen.
- R7: The window passes (`found`) only if the chosen byte has bits 3:0 equal to 3 (last packet) and the byte after it is 0x00. Any other type or status gives `error`. The result appears two cycles after the 4th byte is accepted.
- R8: In acknowledge mode, a window with no 0xC start field in positions 0 to 2 gives `error`.
- R9: `found` and `error` are never high together. Each holds until the next `start`. Bytes that arrive while `busy` is 0 change neither flag and raise no `pay_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that arms a new scan and clears the flags |
| mode | input | 1 | Sampled at start: 0 read scan, 1 acknowledge check |
| crc_en | input | 1 | Sampled at start: read payload carries two extra check bytes |
| byte_valid | input | 1 | A received byte is present on byte_in |
| byte_in | input | 8 | Received byte |
| busy | output | 1 | A scan is in progress |
| found | output | 1 | Scan finished successfully (held) |
| error | output | 1 | Scan failed (held) |
| pay_valid | output | 1 | Strobe for one forwarded payload byte |
| pay_data | output | 8 | Forwarded payload byte |

## Verification
The bench uses the default parameters: a scan limit of 8 bytes, a 4-byte payload with 2 check bytes, and a 4-byte acknowledge window. With these values both search bounds are reached by short sequences. Read cases place the tag at position 0, at position 2 and at position 7, the last legal one, and a sequence of 8 filler bytes has to end in an error. The acknowledge window is small enough to try every placement of the start byte. This includes a stale passing acknowledgement followed by a failing later one, and a start byte only in the excluded last position.

// File: rtl/spi_tag_scanner.sv
module spi_tag_scanner #(
  parameter int          SCAN_LIMIT    = 8,
  parameter int          PAYLOAD_BYTES = 4,
  parameter int          CRC_BYTES     = 2,
  parameter int          ACK_WINDOW    = 4,
  parameter logic [3:0]  DATA_TAG      = 4'hF,
  parameter logic [3:0]  RSP_TAG       = 4'hC,
  parameter logic [3:0]  LAST_TYPE     = 4'h3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mode,
  input  logic       crc_en,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  output logic       busy,
  output logic       found,
  output logic       error,
  output logic       pay_valid,
  output logic [7:0] pay_data
);

  localparam int CW = $clog2(SCAN_LIMIT + 1);
  localparam int PW = $clog2(PAYLOAD_BYTES + CRC_BYTES + 1);
  localparam int WW = $clog2(ACK_WINDOW);

  typedef enum logic [2:0] {IDLE, SEEK, PAY, COLLECT, EVAL} state_t;

  state_t        state;
  logic          mode_q;
  logic [CW-1:0] seek_cnt;
  logic [PW-1:0] pay_left;
  logic [WW-1:0] widx;
  logic [7:0]    win [ACK_WINDOW];

  logic          hit;
  logic [WW-1:0] sel;
  logic          ack_ok;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = 0; i < ACK_WINDOW - 1; i++)
      if (win[i][7:4] == RSP_TAG) begin
        hit = 1'b1;
        sel = WW'(i);
      end
  end

  assign ack_ok = hit && (win[sel][3:0] == LAST_TYPE) && (win[sel + 1'b1] == 8'h00);
  assign busy   = (state != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      mode_q    <= 1'b0;
      seek_cnt  <= '0;
      pay_left  <= '0;
      widx      <= '0;
      found     <= 1'b0;
      error     <= 1'b0;
      pay_valid <= 1'b0;
      pay_data  <= '0;
      for (int i = 0; i < ACK_WINDOW; i++) win[i] <= '0;
    end else begin
      pay_valid <= 1'b0;
      if (start) begin
        found    <= 1'b0;
        error    <= 1'b0;
        mode_q   <= mode;
        seek_cnt <= '0;
        widx     <= '0;
        pay_left <= crc_en ? PW'(PAYLOAD_BYTES + CRC_BYTES) : PW'(PAYLOAD_BYTES);
        state    <= mode ? COLLECT : SEEK;
      end else begin
        case (state)
          SEEK: if (byte_valid) begin
            if (byte_in[7:4] == DATA_TAG) begin
              state <= PAY;
            end else if (seek_cnt == CW'(SCAN_LIMIT - 1)) begin
              error <= 1'b1;
              state <= IDLE;
            end else begin
              seek_cnt <= seek_cnt + 1'b1;
            end
          end
          PAY: if (byte_valid) begin
            pay_valid <= 1'b1;
            pay_data  <= byte_in;
            pay_left  <= pay_left - 1'b1;
            if (pay_left == PW'(1)) begin
              found <= 1'b1;
              state <= IDLE;
            end
          end
          COLLECT: if (byte_valid) begin
            win[widx] <= byte_in;
            widx      <= widx + 1'b1;
            if (widx == WW'(ACK_WINDOW - 1)) state <= EVAL;
          end
          EVAL: begin
            found <= ack_ok;
            error <= !ack_ok;
            state <= IDLE;
          end
          default: state <= IDLE;
        endcase
      end
    end
  end

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && error));
  a_r9_found_held: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !start) |=> found);
  a_r9_error_held: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!found && !error && !pay_valid && busy));
  a_r3_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    seek_cnt < CW'(SCAN_LIMIT));
  a_r4_pay_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pay_left <= PW'(PAYLOAD_BYTES + CRC_BYTES));
  a_r5_no_pay_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !pay_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!pay_valid && $stable(found) && $stable(error)));

endmodule

// File: tb/spi_tag_scanner_tb.sv
module spi_tag_scanner_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, mode = 1'b0, crc_en = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       busy, found, error, pay_valid;
  logic [7:0] pay_data;

  int checks = 0, fails = 0;
  int pay_cnt;
  logic [7:0] pay_log [8];
  bit done = 0;

  always #5 clk = ~clk;

  spi_tag_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .crc_en(crc_en),
    .byte_valid(byte_valid), .byte_in(byte_in), .busy(busy), .found(found),
    .error(error), .pay_valid(pay_valid), .pay_data(pay_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic arm(input logic m, input logic c);
    @(negedge clk);
    start = 1'b1; mode = m; crc_en = c;
    @(negedge clk);
    start = 1'b0;
    check(!found && !error && !pay_valid && busy, "R1", {found, error, pay_valid, busy}, 4'b0001);
    pay_cnt = 0;
  endtask

  task automatic send(input logic [7:0] b);
    byte_valid = 1'b1; byte_in = b;
    @(negedge clk);
    byte_valid = 1'b0;
    if (pay_valid) begin
      if (pay_cnt < 8) pay_log[pay_cnt] = pay_data;
      pay_cnt++;
    end
  endtask

  task automatic read_case(input int fill, input logic c, input string req);
    int n;
    n = c ? 6 : 4;
    arm(1'b0, c);
    for (int i = 0; i < fill; i++) send((i % 2) ? 8'hE3 : 8'h00);
    send(8'hF3);
    check(pay_cnt == 0, "R5", pay_cnt, 0);
    for (int i = 0; i < n; i++) begin
      send(8'h10 + 8'(i));
      if (i < n - 1) check(!found, req, found, 0);
    end
    check(pay_cnt == n, "R4", pay_cnt, n);
    for (int i = 0; i < n; i++) check(pay_log[i] == 8'h10 + 8'(i), "R4", pay_log[i], 8'h10 + i);
    check(found && !error && !busy, req, {found, error, busy}, 3'b100);
  endtask

  task automatic read_timeout();
    arm(1'b0, 1'b0);
    for (int i = 0; i < 7; i++) send(8'h00);
    check(!error && busy, "R3", {error, busy}, 2'b01);
    send(8'hE0);
    check(error && !found && pay_cnt == 0, "R3", {found, error}, 2'b01);
    send(8'h55);
    check(pay_cnt == 0, "R3", pay_cnt, 0);
  endtask

  task automatic ack_case(input logic [7:0] b0, b1, b2, b3, input bit pass, input string req);
    arm(1'b1, 1'b0);
    send(b0); send(b1); send(b2); send(b3);
    check(!found && !error, "R7", {found, error}, 2'b00);
    @(negedge clk);
    check(found == pass && error == !pass && pay_cnt == 0, req, {found, error}, {pass, !pass});
  endtask

  task automatic idle_ignored();
    logic f0, e0;
    f0 = found; e0 = error;
    send(8'hF3); send(8'h12); send(8'hC3); send(8'h00);
    @(negedge clk);
    check(found == f0 && error == e0 && pay_cnt == 0, "R9", {found, error}, {f0, e0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!found && !error && !pay_valid && !busy, "R1", {found, error, pay_valid, busy}, 0);
    rst_n = 1'b1;
    read_case(0, 1'b0, "R4");
    read_case(2, 1'b0, "R2");
    read_case(0, 1'b1, "R4");
    read_case(7, 1'b0, "R2");
    pay_cnt = 0;
    idle_ignored();
    read_timeout();
    pay_cnt = 0;
    idle_ignored();
    ack_case(8'hC3, 8'h00, 8'h00, 8'h00, 1, "R6");
    ack_case(8'hC3, 8'h00, 8'hC3, 8'h00, 1, "R6");
    ack_case(8'hC3, 8'h00, 8'hC1, 8'h00, 0, "R6");
    ack_case(8'hC3, 8'h00, 8'hC3, 8'h07, 0, "R7");
    ack_case(8'hC3, 8'h05, 8'h00, 8'h00, 0, "R7");
    ack_case(8'h00, 8'hC2, 8'h00, 8'h00, 0, "R7");
    ack_case(8'h00, 8'h00, 8'h00, 8'hC3, 0, "R8");
    ack_case(8'h11, 8'h22, 8'h33, 8'h44, 0, "R8");
    pay_cnt = 0;
    idle_ignored();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule